// File: doc/BRIEF.md
# Memory Operand Offset Generator

This block turns the addressing fields of an instruction's operand descriptor into a memory offset. It handles both 16-bit and 32-bit address sizes. The instruction decoder hands over the two-bit mode field and the three-bit r/m field of the ModRM byte with a `start` strobe, together with the address-size flag. The block then pulls the bytes that follow from a byte stream with a valid/ready handshake. These are an optional scale-index-base (SIB) byte and zero, one, two or four displacement bytes. All eight general registers are presented side by side on a flat input, and they must stay stable until `done`.

When the last needed byte has been taken, the block pulses `done` for one cycle. With that pulse it presents the offset, a flag that asks for the stack segment as the default segment, and the number of stream bytes it used. Segment base addition, limit checking and register-direct operands are left to the surrounding pipeline.

Top module: `ea_gen`

## Requirements
- R1: While reset is asserted and after it ends, `done`, `in_ready`, `ea`, `stack_seg` and `used_bytes` are all zero until a request completes.
- R2: A `start` is taken only when the block is idle and `modrm_mod` is not 3. A mode-3 request, or a `start` (with any field values) while a request is running, leaves the running result and the stream untouched. A mode-3 request never raises `in_ready` or `done`.
- R3: In 16-bit mode, r/m selects BX+SI (0), BX+DI (1), BP+SI (2), BP+DI (3), SI (4), DI (5), BP (6) or BX (7). Register number n sits at `gpr[32n+31:32n]`, with AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7. Only the low 16 bits of each register are used, the sum wraps modulo 65536, and `ea[31:16]` is zero.
- R4: In 16-bit mode, `stack_seg` is 1 for r/m 2 and 3 in every mode, and for r/m 6 in modes 1 and 2. Otherwise it is 0.
- R5: In 16-bit mode, mode 0 with r/m 6 uses no register: the offset is a 2-byte displacement.
- R6: Mode 1 adds one displacement byte, sign-extended. Mode 2 adds a 2-byte displacement in 16-bit mode and a 4-byte displacement in 32-bit mode. Multi-byte displacements arrive least significant byte first. A stream byte is taken only in a cycle where `in_valid` and `in_ready` are both high.
- R7: In 32-bit mode with r/m other than 4, the offset is register[r/m] plus the displacement. Mode 0 with r/m 5 is a 4-byte direct displacement with no register. `stack_seg` is 1 exactly for r/m 5 in modes 1 and 2.
- R8: In 32-bit mode with r/m 4, the first stream byte is a SIB byte. Its bits 7:6 give the scale s, bits 5:3 the index and bits 2:0 the base. The offset is base + (index << s) + displacement, and an index of 4 adds nothing.
- R9: With a SIB base of 5, mode 0 replaces the base register with a 4-byte displacement (and `stack_seg` is 0). Modes 1 and 2 use EBP as the base and set `stack_seg`. A SIB base of 4 (ESP) also sets `stack_seg`.
- R10: `used_bytes` equals the SIB bytes plus the displacement bytes taken (0 to 5). `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, sampled while idle |
| addr32 | input | 1 | 1 selects 32-bit addressing, 0 selects 16-bit |
| modrm_mod | input | 2 | Mode field of the ModRM byte |
| modrm_rm | input | 3 | r/m field of the ModRM byte |
| gpr | input | 256 | Eight 32-bit general registers, register n at bits 32n+31:32n |
| in_valid | input | 1 | Stream byte is present |
| in_byte | input | 8 | Stream byte (SIB or displacement) |
| in_ready | output | 1 | Block will take a stream byte this cycle |
| done | output | 1 | One-cycle pulse: result outputs are fresh |
| ea | output | 32 | Computed offset |
| stack_seg | output | 1 | Default segment is the stack segment |
| used_bytes | output | 3 | Stream bytes used by this request |

## Verification
The bench visits every 16-bit r/m row. A swapped BP/BX pair would show up as a wrong sum or a missing stack flag on rows 2, 3 and 6. Several cases aim at the easy mistakes:
- a negative 8-bit displacement, which fails if it is zero-extended;
- a 16-bit sum that must wrap rather than carry into bit 16;
- a register with nonzero upper bits used in 16-bit mode;
- the SIB cases for index 4, base 4 and base 5 in both mode 0 and mode 1, where applying the base-5 replacement in every mode gives a wrong offset and too few bytes.

Stalled streams, mode-3 requests and a second `start` while a request is running confirm that the latched fields, not the live inputs, steer the request.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_REGS   = 8;
  localparam int GPR_W      = REG_W * NUM_REGS;
  localparam int LANE_W     = 8;
  localparam int DISP_LANES = REG_W / LANE_W;
  localparam int LANE_IDX_W = $clog2(DISP_LANES);
  localparam int CNT_W      = 3;
  localparam int HALF_W     = REG_W / 2;

  localparam logic [2:0] R_BX = 3'd3;
  localparam logic [2:0] R_SP = 3'd4;
  localparam logic [2:0] R_BP = 3'd5;
  localparam logic [2:0] R_SI = 3'd6;
  localparam logic [2:0] R_DI = 3'd7;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SIB    = 2'd1,
    ST_DISP   = 2'd2,
    ST_FINISH = 2'd3
  } ea_state_e;

  function automatic logic [REG_W-1:0] reg_at(input logic [GPR_W-1:0] g, input logic [2:0] n);
    return g[int'(n)*REG_W +: REG_W];
  endfunction

  // Displacement length in bytes for the given encoding.
  function automatic logic [CNT_W-1:0] disp_bytes(input logic a32, input logic [1:0] md,
                                                   input logic [2:0] rm, input logic [2:0] sbase);
    logic [CNT_W-1:0] n;
    if (md == 2'd1)      n = 3'd1;
    else if (md == 2'd2) n = a32 ? 3'd4 : 3'd2;
    else if (a32)        n = ((rm == R_BP) || ((rm == R_SP) && (sbase == R_BP))) ? 3'd4 : 3'd0;
    else                 n = (rm == R_SI) ? 3'd2 : 3'd0;
    return n;
  endfunction

  function automatic logic stack_default(input logic a32, input logic [1:0] md,
                                         input logic [2:0] rm, input logic [2:0] sbase);
    logic s;
    if (!a32)              s = (rm == 3'd2) || (rm == 3'd3) || ((rm == 3'd6) && (md != 2'd0));
    else if (rm == R_SP)   s = (sbase == R_SP) || ((sbase == R_BP) && (md != 2'd0));
    else                   s = (rm == R_BP) && (md != 2'd0);
    return s;
  endfunction

  function automatic logic [HALF_W-1:0] ea16(input logic [1:0] md, input logic [2:0] rm,
                                             input logic [GPR_W-1:0] g, input logic [HALF_W-1:0] d);
    logic [HALF_W-1:0] bx, bp, si, di, base;
    bx = reg_at(g, R_BX)[HALF_W-1:0];
    bp = reg_at(g, R_BP)[HALF_W-1:0];
    si = reg_at(g, R_SI)[HALF_W-1:0];
    di = reg_at(g, R_DI)[HALF_W-1:0];
    case (rm)
      3'd0:    base = bx + si;
      3'd1:    base = bx + di;
      3'd2:    base = bp + si;
      3'd3:    base = bp + di;
      3'd4:    base = si;
      3'd5:    base = di;
      3'd6:    base = (md == 2'd0) ? '0 : bp;
      default: base = bx;
    endcase
    return base + d;
  endfunction

  function automatic logic [REG_W-1:0] ea32(input logic [1:0] md, input logic [2:0] rm,
                                            input logic [7:0] sib, input logic [GPR_W-1:0] g,
                                            input logic [REG_W-1:0] d);
    logic [REG_W-1:0] base, idx;
    if (rm == R_SP) begin
      base = ((md == 2'd0) && (sib[2:0] == R_BP)) ? '0 : reg_at(g, sib[2:0]);
      idx  = (sib[5:3] == R_SP) ? '0 : (reg_at(g, sib[5:3]) << sib[7:6]);
    end else begin
      base = ((md == 2'd0) && (rm == R_BP)) ? '0 : reg_at(g, rm);
      idx  = '0;
    end
    return base + idx + d;
  endfunction
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic             a32,
  input  logic [1:0]       md,
  input  logic [2:0]       rm,
  input  logic [2:0]       sib_base,
  output logic             need_sib,
  output logic [CNT_W-1:0] disp_len,
  output logic             stack_sel
);
  always_comb begin
    need_sib  = a32 && (rm == R_SP);
    disp_len  = disp_bytes(a32, md, rm, sib_base);
    stack_sel = stack_default(a32, md, rm, sib_base);
  end
endmodule

// File: rtl/ea_disp_collect.sv
module ea_disp_collect
  import ea_pkg::*;
#(
  parameter int LANES = DISP_LANES,
  parameter int LW    = LANE_W,
  localparam int IW   = $clog2(LANES),
  localparam int OW   = LANES * LW
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [LW-1:0]    wr_byte,
  input  logic [CNT_W-1:0] len,
  output logic [OW-1:0]    disp_val
);
  logic [OW-1:0] raw;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  lane_q <= '0;
      else if (clear)                              lane_q <= '0;
      else if (wr_en && (wr_idx == IW'(i)))        lane_q <= wr_byte;
    end
    assign raw[i*LW +: LW] = lane_q;
  end

  always_comb begin
    case (len)
      3'd0:    disp_val = '0;
      3'd1:    disp_val = {{(OW-LW){raw[LW-1]}}, raw[LW-1:0]};
      3'd2:    disp_val = {{(OW-2*LW){1'b0}}, raw[2*LW-1:0]};
      default: disp_val = raw;
    endcase
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (raw == '0)); // R6
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
(
  input  logic             a32,
  input  logic [1:0]       md,
  input  logic [2:0]       rm,
  input  logic [7:0]       sib,
  input  logic [REG_W-1:0] disp,
  input  logic [GPR_W-1:0] gpr,
  output logic [REG_W-1:0] ea
);
  always_comb begin
    if (a32) ea = ea32(md, rm, sib, gpr, disp);
    else     ea = {{(REG_W-HALF_W){1'b0}}, ea16(md, rm, gpr, disp[HALF_W-1:0])};
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             addr32,
  input  logic [1:0]       modrm_mod,
  input  logic [2:0]       modrm_rm,
  input  logic [GPR_W-1:0] gpr,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             done,
  output logic [REG_W-1:0] ea,
  output logic             stack_seg,
  output logic [CNT_W-1:0] used_bytes
);
  ea_state_e             state_q;
  logic                  a32_q;
  logic [1:0]            md_q;
  logic [2:0]            rm_q;
  logic [7:0]            sib_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [LANE_IDX_W-1:0] dpos_q;

  // Named internal events
  logic accept_start, byte_fire, last_disp;
  logic dec_a32, dec_need_sib, dec_stack;
  logic [1:0] dec_md;
  logic [2:0] dec_rm, dec_sbase;
  logic [CNT_W-1:0] dec_len;
  logic [REG_W-1:0] disp_val, ea_next;

  assign in_ready     = (state_q == ST_SIB) || (state_q == ST_DISP);
  assign accept_start = start && (state_q == ST_IDLE) && (modrm_mod != 2'b11);
  assign byte_fire    = in_valid && in_ready;

  // One decoder: live fields while idle, latched fields afterwards
  assign dec_a32   = (state_q == ST_IDLE) ? addr32    : a32_q;
  assign dec_md    = (state_q == ST_IDLE) ? modrm_mod : md_q;
  assign dec_rm    = (state_q == ST_IDLE) ? modrm_rm  : rm_q;
  assign dec_sbase = (state_q == ST_SIB)  ? in_byte[2:0] : sib_q[2:0];
  assign last_disp = ({1'b0, dpos_q} == (dec_len - 3'd1));

  ea_decode u_dec (
    .a32(dec_a32), .md(dec_md), .rm(dec_rm), .sib_base(dec_sbase),
    .need_sib(dec_need_sib), .disp_len(dec_len), .stack_sel(dec_stack)
  );

  ea_disp_collect u_disp (
    .clk(clk), .rst_n(rst_n), .clear(accept_start),
    .wr_en(byte_fire && (state_q == ST_DISP)), .wr_idx(dpos_q), .wr_byte(in_byte),
    .len(dec_len), .disp_val(disp_val)
  );

  ea_addr_calc u_calc (
    .a32(a32_q), .md(md_q), .rm(rm_q), .sib(sib_q), .disp(disp_val), .gpr(gpr), .ea(ea_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      a32_q      <= 1'b0;
      md_q       <= '0;
      rm_q       <= '0;
      sib_q      <= '0;
      cnt_q      <= '0;
      dpos_q     <= '0;
      done       <= 1'b0;
      ea         <= '0;
      stack_seg  <= 1'b0;
      used_bytes <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept_start) begin
          a32_q  <= addr32;
          md_q   <= modrm_mod;
          rm_q   <= modrm_rm;
          cnt_q  <= '0;
          dpos_q <= '0;
          if (dec_need_sib)       state_q <= ST_SIB;
          else if (dec_len != '0) state_q <= ST_DISP;
          else                    state_q <= ST_FINISH;
        end
        ST_SIB: if (byte_fire) begin
          sib_q   <= in_byte;
          cnt_q   <= cnt_q + 3'd1;
          state_q <= (dec_len != '0) ? ST_DISP : ST_FINISH;
        end
        ST_DISP: if (byte_fire) begin
          dpos_q <= dpos_q + 1'b1;
          cnt_q  <= cnt_q + 3'd1;
          if (last_disp) state_q <= ST_FINISH;
        end
        default: begin
          done       <= 1'b1;
          ea         <= ea_next;
          stack_seg  <= dec_stack;
          used_bytes <= cnt_q;
          state_q    <= ST_IDLE;
        end
      endcase
    end
  end

  AST_NO_MOD3_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && modrm_mod == 2'b11) |=> (state_q == ST_IDLE)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_USED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (used_bytes <= 3'd5)); // R10
  AST_WRAP16: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !a32_q) |-> (ea[REG_W-1:HALF_W] == '0)); // R3
  AST_SIB_ONLY32: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SIB) |-> a32_q); // R8
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  typedef struct packed {
    logic        a32;
    logic [1:0]  md;
    logic [2:0]  rm;
    logic [7:0]  sib;
    logic [31:0] disp;
    logic [31:0] ea;
    logic        ss;
    logic [2:0]  used;
  } vec_t;

  // EAX..EDI = 1000, 200, 30, ABCD1234, F000, 8000, 10100, 20 (hex)
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 3'd0, 8'h00, 32'h0,        32'h00001334, 1'b0, 3'd0},
    '{1'b0, 2'd0, 3'd1, 8'h00, 32'h0,        32'h00001254, 1'b0, 3'd0},
    '{1'b0, 2'd0, 3'd2, 8'h00, 32'h0,        32'h00008100, 1'b1, 3'd0},
    '{1'b0, 2'd0, 3'd3, 8'h00, 32'h0,        32'h00008020, 1'b1, 3'd0},
    '{1'b0, 2'd0, 3'd4, 8'h00, 32'h0,        32'h00000100, 1'b0, 3'd0},
    '{1'b0, 2'd0, 3'd5, 8'h00, 32'h0,        32'h00000020, 1'b0, 3'd0},
    '{1'b0, 2'd0, 3'd6, 8'h00, 32'h0000BEEF, 32'h0000BEEF, 1'b0, 3'd2},
    '{1'b0, 2'd0, 3'd7, 8'h00, 32'h0,        32'h00001234, 1'b0, 3'd0},
    '{1'b0, 2'd1, 3'd6, 8'h00, 32'h00000080, 32'h00007F80, 1'b1, 3'd1},
    '{1'b0, 2'd1, 3'd0, 8'h00, 32'h00000010, 32'h00001344, 1'b0, 3'd1},
    '{1'b0, 2'd2, 3'd7, 8'h00, 32'h0000F000, 32'h00000234, 1'b0, 3'd2},
    '{1'b0, 2'd2, 3'd3, 8'h00, 32'h00000010, 32'h00008030, 1'b1, 3'd2},
    '{1'b1, 2'd0, 3'd0, 8'h00, 32'h0,        32'h00001000, 1'b0, 3'd0},
    '{1'b1, 2'd0, 3'd5, 8'h00, 32'h12345678, 32'h12345678, 1'b0, 3'd4},
    '{1'b1, 2'd1, 3'd5, 8'h00, 32'h000000FE, 32'h00007FFE, 1'b1, 3'd1},
    '{1'b1, 2'd2, 3'd3, 8'h00, 32'h00000010, 32'hABCD1244, 1'b0, 3'd4},
    '{1'b1, 2'd1, 3'd6, 8'h00, 32'h0000007F, 32'h0001017F, 1'b0, 3'd1},
    '{1'b1, 2'd0, 3'd4, 8'h8B, 32'h0,        32'hABCD1A34, 1'b0, 3'd1},
    '{1'b1, 2'd0, 3'd4, 8'h20, 32'h0,        32'h00001000, 1'b0, 3'd1},
    '{1'b1, 2'd0, 3'd4, 8'hFD, 32'h00001000, 32'h00001100, 1'b0, 3'd5},
    '{1'b1, 2'd1, 3'd4, 8'h35, 32'h00000004, 32'h00018104, 1'b1, 3'd2},
    '{1'b1, 2'd0, 3'd4, 8'h24, 32'h0,        32'h0000F000, 1'b1, 3'd1},
    '{1'b1, 2'd2, 3'd4, 8'h42, 32'hFFFFFFF0, 32'h00002020, 1'b0, 3'd5},
    '{1'b1, 2'd2, 3'd2, 8'h00, 32'h80000000, 32'h80000030, 1'b0, 3'd4},
    '{1'b0, 2'd2, 3'd6, 8'h00, 32'h00000100, 32'h00008100, 1'b1, 3'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, addr32 = 1'b0, in_valid = 1'b0;
  logic [1:0] modrm_mod = '0;
  logic [2:0] modrm_rm = '0;
  logic [7:0] in_byte = '0;
  logic [255:0] gpr = {32'h00000020, 32'h00010100, 32'h00008000, 32'h0000F000,
                       32'hABCD1234, 32'h00000030, 32'h00000200, 32'h00001000};
  logic in_ready, done, stack_seg;
  logic [31:0] ea;
  logic [2:0] used_bytes;

  int nchk = 0, nfail = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr32(addr32),
    .modrm_mod(modrm_mod), .modrm_rm(modrm_rm), .gpr(gpr),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .done(done), .ea(ea), .stack_seg(stack_seg), .used_bytes(used_bytes)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic has_sib(vec_t v);
    return v.a32 && (v.rm == 3'd4);
  endfunction

  function automatic logic [7:0] byte_of(vec_t v, int k);
    if (has_sib(v)) begin
      if (k == 0) return v.sib;
      return v.disp[8*(k-1) +: 8];
    end
    return v.disp[8*k +: 8];
  endfunction

  function automatic string ea_tag(vec_t v);
    if (!v.a32) begin
      if (v.md == 2'd0 && v.rm == 3'd6) return "R5";
      if (v.md != 2'd0) return "R6";
      return "R3";
    end
    if (v.rm == 3'd4) return (v.sib[2:0] == 3'd5 || v.sib[2:0] == 3'd4) ? "R9" : "R8";
    return "R7";
  endfunction

  task automatic run(input int i, input bit inject);
    vec_t v;
    int k;
    bit got;
    logic [31:0] got_ea;
    logic got_ss;
    logic [2:0] got_used;
    v = VECS[i];
    @(negedge clk);
    addr32 = v.a32; modrm_mod = v.md; modrm_rm = v.rm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; got = 1'b0; got_ea = '0; got_ss = 1'b0; got_used = '0;
    for (int t = 0; t < 40 && !got; t++) begin
      if (done) begin
        got = 1'b1; got_ea = ea; got_ss = stack_seg; got_used = used_bytes;
      end else begin
        if (in_ready && !((i % 2 == 1) && (t % 2 == 0))) begin
          in_valid = 1'b1; in_byte = byte_of(v, k); k++;
        end
        if (inject && in_ready && t == 0) begin
          start = 1'b1; addr32 = ~v.a32; modrm_mod = 2'd0; modrm_rm = 3'd4;
        end
        @(negedge clk);
        start = 1'b0; in_valid = 1'b0;
      end
    end
    if (!got) chk("R10 done never seen", 32'd0, 32'd1);
    chk(ea_tag(v), got_ea, v.ea);
    chk(v.a32 ? ea_tag(v) : "R4", {31'd0, got_ss}, {31'd0, v.ss});
    chk("R10 used_bytes", {29'd0, got_used}, {29'd0, v.used});
    chk("R6 stream bytes taken", k, {29'd0, v.used});
    @(negedge clk);
    chk("R10 done pulse width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nfail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    chk("R1 in_ready in reset", {31'd0, in_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ea after reset", ea, 32'd0);
    chk("R1 flags after reset", {28'd0, stack_seg, used_bytes}, 32'd0);

    for (int i = 0; i < NV; i++) run(i, 1'b0);

    // Mode 3 request is ignored
    @(negedge clk);
    addr32 = 1'b1; modrm_mod = 2'b11; modrm_rm = 3'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 6; t++) begin
      chk("R2 mode 3 ready", {31'd0, in_ready}, 32'd0);
      chk("R2 mode 3 done", {31'd0, done}, 32'd0);
      @(negedge clk);
    end

    // start during a running request with other fields
    run(10, 1'b1);
    run(22, 1'b1);
    for (int t = 0; t < 3; t++) begin
      chk("R2 no stray request", {30'd0, in_ready, done}, 32'd0);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule